// File: doc/BRIEF.md
# Two-Level Router Switch Allocator

This block decides, each cycle, which buffered packets in an input-buffered router may cross the switch. Each input port holds several candidate packets. The allocator sees one descriptor per candidate:

- valid bit;
- target output;
- traffic class;
- a flag marking traffic that arrived from another router rather than from the local node;
- a small age value.

It returns one grant matrix (output by input), plus a one-hot mark of the winning candidate slot at every input that was granted.

Allocation runs at two levels:

- **Local nomination.** Every input picks one candidate among its own packets. A candidate qualifies only if it is valid and its target output is not reported busy. The chosen packet is forwarded as that input's single nomination.
- **Output arbitration.** Every output then picks one of the nominations aimed at it.

Both levels rank candidates by the same key: class first (responses above requests), then origin (through-traffic above locally injected traffic), then age (older above younger). A least-recently-selected order breaks exact ties. That order is held per input over its slots and per output over the inputs. It moves only when a grant is issued. Grants are combinational from the descriptors, and the fairness state advances on the clock edge that follows.

Top module: `swaAllocator`

## Requirements
- R1: A candidate is granted only if its valid bit is 1 and the `outBusy` bit of its target output is 0. An invalid candidate or one aimed at a busy output has no effect on any grant. When the busy output frees up, the input nominates that candidate again without further action.
- R2: Each output grants at most one input per cycle, and each input receives at most one grant per cycle. `grantSlot[i]` is one-hot exactly when some `grantOut[o][i]` is 1, and it marks the slot whose target is `o`.
- R3: Whenever at least one candidate is valid and aimed at a non-busy output, at least one grant is issued in that cycle.
- R4: At both levels, a candidate with `pktResp`=1 (response class) beats one with `pktResp`=0 (request class), whatever their origin or age.
- R5: Among candidates of equal class, one with `pktFromNet`=1 (through-traffic) beats one with `pktFromNet`=0 (locally injected), whatever their age.
- R6: Among candidates of equal class and origin, the larger `pktAge` value wins.
- R7: When nominations to one output carry equal keys, the input granted least recently at that output wins. After reset, lower input indices rank first.
- R8: When eligible slots of one input carry equal keys, the slot granted least recently at that input wins. After reset, lower slot indices rank first.
- R9: The least-recently-selected order changes only on the edge after a grant. Cycles with losing, blocked or absent requests leave it untouched.
- R10: An input presents exactly one nomination per cycle. If that nomination loses at its output, the input receives no grant in that cycle, even when another of its slots targets a free output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; fairness state updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the fairness state |
| pktValid | input | NIN*NSLOT | Candidate present, per input and slot |
| pktDest | input | NIN*NSLOT*OUT_W | Target output index of each candidate |
| pktResp | input | NIN*NSLOT | 1 = response class, 0 = request class |
| pktFromNet | input | NIN*NSLOT | 1 = arrived from the network, 0 = locally injected |
| pktAge | input | NIN*NSLOT*AGE_W | Age of each candidate, larger is older |
| outBusy | input | NOUT | 1 = that output cannot accept a packet this cycle |
| grantOut | output | NOUT*NIN | `grantOut[o][i]` = output o grants input i |
| grantSlot | output | NIN*NSLOT | One-hot winning slot of each granted input |

## Verification
Local nomination and output arbitration resolve in the same cycle. The sharpest case is an input whose chosen slot loses at its output while its other slot aims at an idle output. The bench builds this by giving a competing input a higher-ranked packet at that output, then checks that the idle output stays silent.

Priority overrides at both levels are also made to fall in one cycle. In a single step, a class decision at one input coincides with a class decision at an output against a fairness order that favours the loser. Both grants are compared against values computed by hand.

// File: rtl/swaPkg.sv
package swaPkg;
  localparam int NIN   = 4;
  localparam int NOUT  = 4;
  localparam int NSLOT = 2;
  localparam int AGE_W = 3;
  localparam int OUT_W = (NOUT > 1) ? $clog2(NOUT) : 1;
  // key layout: {class, fromNet, age}, larger value ranks higher
  localparam int KEY_W = AGE_W + 2;

  typedef struct packed {
    logic [NIN-1:0][NSLOT-1:0] slotWin;  // advance per-input slot order
    logic [NOUT-1:0][NIN-1:0]  outWin;   // advance per-output input order
  } lrsStrobe_t;
endpackage

// File: rtl/swaPickOne.sv
module swaPickOne #(
  parameter int N     = 4,
  parameter int KEY_W = 5
) (
  input  logic [N-1:0]            req,
  input  logic [N-1:0][KEY_W-1:0] key,
  input  logic [N-1:0][N-1:0]     prec,
  output logic [N-1:0]            win
);
  logic [N-1:0] beats;

  // A requester wins when no other requester outranks it by key,
  // and on equal key it holds precedence in the fairness matrix.
  always_comb begin
    for (int c = 0; c < N; c++) begin
      beats[c] = 1'b1;
      for (int d = 0; d < N; d++) begin
        if (d != c && req[d]) begin
          if (key[d] > key[c] || (key[d] == key[c] && !prec[c][d]))
            beats[c] = 1'b0;
        end
      end
      win[c] = req[c] & beats[c];
    end
  end
endmodule

// File: rtl/swaLrsMatrix.sv
module swaLrsMatrix #(
  parameter int N = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N-1:0]       upd,
  output logic [N-1:0][N-1:0] prec
);
  // prec[a][b] = 1 : a was selected less recently than b
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < N; a++)
        for (int b = 0; b < N; b++)
          prec[a][b] <= (a < b);
    end else if (|upd) begin
      for (int a = 0; a < N; a++)
        for (int b = 0; b < N; b++)
          if (a != b) begin
            if (upd[a])      prec[a][b] <= 1'b0;
            else if (upd[b]) prec[a][b] <= 1'b1;
          end
    end
  end
endmodule

// File: rtl/swaLrsCtrl.sv
module swaLrsCtrl
  import swaPkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  lrsStrobe_t                          strobe,
  output logic [NIN-1:0][NSLOT-1:0][NSLOT-1:0] localPrec,
  output logic [NOUT-1:0][NIN-1:0][NIN-1:0]    globPrec
);
  for (genvar i = 0; i < NIN; i++) begin : g_local
    swaLrsMatrix #(.N(NSLOT)) u_slotOrder (
      .clk (clk),
      .rstN(rstN),
      .upd (strobe.slotWin[i]),
      .prec(localPrec[i])
    );
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_global
    swaLrsMatrix #(.N(NIN)) u_inOrder (
      .clk (clk),
      .rstN(rstN),
      .upd (strobe.outWin[o]),
      .prec(globPrec[o])
    );
  end
endmodule

// File: rtl/swaDatapath.sv
module swaDatapath
  import swaPkg::*;
(
  input  logic [NIN-1:0][NSLOT-1:0]            pktValid,
  input  logic [NIN-1:0][NSLOT-1:0][OUT_W-1:0] pktDest,
  input  logic [NIN-1:0][NSLOT-1:0]            pktResp,
  input  logic [NIN-1:0][NSLOT-1:0]            pktFromNet,
  input  logic [NIN-1:0][NSLOT-1:0][AGE_W-1:0] pktAge,
  input  logic [NOUT-1:0]                      outBusy,
  input  logic [NIN-1:0][NSLOT-1:0][NSLOT-1:0] localPrec,
  input  logic [NOUT-1:0][NIN-1:0][NIN-1:0]    globPrec,
  output logic [NOUT-1:0][NIN-1:0]             grantOut,
  output logic [NIN-1:0][NSLOT-1:0]            grantSlot,
  output lrsStrobe_t                           strobe
);
  logic [NIN-1:0][NSLOT-1:0]            slotReq;
  logic [NIN-1:0][NSLOT-1:0][KEY_W-1:0] slotKey;
  logic [NIN-1:0][NSLOT-1:0]            slotSel;
  logic [NIN-1:0]                       nomValid;
  logic [NIN-1:0][OUT_W-1:0]            nomDest;
  logic [NIN-1:0][KEY_W-1:0]            nomKey;
  logic [NOUT-1:0][NIN-1:0]             outReq;
  logic [NIN-1:0]                       inWon;

  // level 1: one nomination per input
  for (genvar i = 0; i < NIN; i++) begin : g_in
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign slotReq[i][s] = pktValid[i][s] & ~outBusy[pktDest[i][s]];
      assign slotKey[i][s] = {pktResp[i][s], pktFromNet[i][s], pktAge[i][s]};
    end
    swaPickOne #(.N(NSLOT), .KEY_W(KEY_W)) u_localPick (
      .req (slotReq[i]),
      .key (slotKey[i]),
      .prec(localPrec[i]),
      .win (slotSel[i])
    );
  end

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      nomValid[i] = |slotReq[i];
      nomDest[i]  = '0;
      nomKey[i]   = '0;
      for (int s = 0; s < NSLOT; s++) begin
        if (slotSel[i][s]) begin
          nomDest[i] = nomDest[i] | pktDest[i][s];
          nomKey[i]  = nomKey[i]  | slotKey[i][s];
        end
      end
    end
  end

  // level 2: one winner per output among the nominations
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    for (genvar i = 0; i < NIN; i++) begin : g_req
      assign outReq[o][i] = nomValid[i] && (nomDest[i] == OUT_W'(o));
    end
    swaPickOne #(.N(NIN), .KEY_W(KEY_W)) u_globalPick (
      .req (outReq[o]),
      .key (nomKey),
      .prec(globPrec[o]),
      .win (grantOut[o])
    );
  end

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      inWon[i] = 1'b0;
      for (int o = 0; o < NOUT; o++) inWon[i] = inWon[i] | grantOut[o][i];
      grantSlot[i] = slotSel[i] & {NSLOT{inWon[i]}};
    end
    strobe.slotWin = grantSlot;
    strobe.outWin  = grantOut;
  end
endmodule

// File: rtl/swaAllocator.sv
module swaAllocator
  import swaPkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NIN-1:0][NSLOT-1:0]            pktValid,
  input  logic [NIN-1:0][NSLOT-1:0][OUT_W-1:0] pktDest,
  input  logic [NIN-1:0][NSLOT-1:0]            pktResp,
  input  logic [NIN-1:0][NSLOT-1:0]            pktFromNet,
  input  logic [NIN-1:0][NSLOT-1:0][AGE_W-1:0] pktAge,
  input  logic [NOUT-1:0]                      outBusy,
  output logic [NOUT-1:0][NIN-1:0]             grantOut,
  output logic [NIN-1:0][NSLOT-1:0]            grantSlot
);
  lrsStrobe_t                          strobe;
  logic [NIN-1:0][NSLOT-1:0][NSLOT-1:0] localPrec;
  logic [NOUT-1:0][NIN-1:0][NIN-1:0]    globPrec;

  swaLrsCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .localPrec(localPrec),
    .globPrec (globPrec)
  );

  swaDatapath u_dp (
    .pktValid  (pktValid),
    .pktDest   (pktDest),
    .pktResp   (pktResp),
    .pktFromNet(pktFromNet),
    .pktAge    (pktAge),
    .outBusy   (outBusy),
    .localPrec (localPrec),
    .globPrec  (globPrec),
    .grantOut  (grantOut),
    .grantSlot (grantSlot),
    .strobe    (strobe)
  );
endmodule

// File: rtl/swaAllocatorChk.sv
module swaAllocatorChk
  import swaPkg::*;
(
  input logic                                 clk,
  input logic                                 rstN,
  input logic [NIN-1:0][NSLOT-1:0]            pktValid,
  input logic [NIN-1:0][NSLOT-1:0][OUT_W-1:0] pktDest,
  input logic [NIN-1:0][NSLOT-1:0]            pktResp,
  input logic [NOUT-1:0]                      outBusy,
  input logic [NOUT-1:0][NIN-1:0]             grantOut,
  input logic [NIN-1:0][NSLOT-1:0]            grantSlot
);
  logic [NIN-1:0][NOUT-1:0]  colVec;
  logic [NIN-1:0][NSLOT-1:0] elig;
  logic                      anyElig;

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      for (int o = 0; o < NOUT; o++) colVec[i][o] = grantOut[o][i];
      for (int s = 0; s < NSLOT; s++)
        elig[i][s] = pktValid[i][s] && !outBusy[pktDest[i][s]];
    end
    anyElig = |elig;
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_o
    a_r2_out_single: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grantOut[o]));
  end

  for (genvar i = 0; i < NIN; i++) begin : g_i
    a_r2_in_single: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(colVec[i]));
    a_r2_slot_match: assert property (@(posedge clk) disable iff (!rstN)
      ((|grantSlot[i]) == (|colVec[i])) && $onehot0(grantSlot[i]));
    for (genvar s = 0; s < NSLOT; s++) begin : g_s
      a_r1_grant_eligible: assert property (@(posedge clk) disable iff (!rstN)
        grantSlot[i][s] |-> (elig[i][s] && grantOut[pktDest[i][s]][i]));
      for (genvar t = 0; t < NSLOT; t++) begin : g_t
        if (t != s) begin : g_pair
          a_r4_local_class: assert property (@(posedge clk) disable iff (!rstN)
            (grantSlot[i][s] && elig[i][t]) |-> !(pktResp[i][t] && !pktResp[i][s]));
        end
      end
    end
  end

  a_r3_progress: assert property (@(posedge clk) disable iff (!rstN)
    anyElig |-> (|grantOut));
endmodule

bind swaAllocator swaAllocatorChk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pktValid (pktValid),
  .pktDest  (pktDest),
  .pktResp  (pktResp),
  .outBusy  (outBusy),
  .grantOut (grantOut),
  .grantSlot(grantSlot)
);

// File: tb/swaAllocator_tb.sv
module swaAllocator_tb;
  import swaPkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NIN-1:0][NSLOT-1:0]            pktValid, pktResp, pktFromNet;
  logic [NIN-1:0][NSLOT-1:0][OUT_W-1:0] pktDest;
  logic [NIN-1:0][NSLOT-1:0][AGE_W-1:0] pktAge;
  logic [NOUT-1:0]                      outBusy;
  logic [NOUT-1:0][NIN-1:0]             grantOut, expG;
  logic [NIN-1:0][NSLOT-1:0]            grantSlot, expS;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swaAllocator u_dut (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktDest(pktDest),
    .pktResp(pktResp), .pktFromNet(pktFromNet), .pktAge(pktAge),
    .outBusy(outBusy), .grantOut(grantOut), .grantSlot(grantSlot)
  );

  task automatic clearIn();
    pktValid = '0; pktResp = '0; pktFromNet = '0;
    pktDest = '0; pktAge = '0; outBusy = '0;
  endtask

  task automatic setPkt(int i, int s, int dest, bit resp, bit net, int age);
    pktValid[i][s]   = 1'b1;
    pktDest[i][s]    = OUT_W'(dest);
    pktResp[i][s]    = resp;
    pktFromNet[i][s] = net;
    pktAge[i][s]     = AGE_W'(age);
  endtask

  task automatic expNone();
    expG = '0; expS = '0;
  endtask

  task automatic addG(int o, int i, int s);
    expG[o][i] = 1'b1; expS[i][s] = 1'b1;
  endtask

  task automatic check(string tag);
    checks++;
    if (grantOut !== expG || grantSlot !== expS) begin
      errors++;
      $display("FAIL %s: grantOut=%h grantSlot=%h expected grantOut=%h grantSlot=%h",
               tag, grantOut, grantSlot, expG, expS);
    end
  endtask

  task automatic checkBit(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive after a falling edge, sample before the next rising edge
  task automatic step();
    @(negedge clk);
    clearIn();
  endtask

  task automatic doReset();
    @(negedge clk);
    clearIn();
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  task automatic tReset();
    doReset();
    step(); #1; expNone(); check("R2 idle after reset");
  endtask

  task automatic tLrsGlobal();  // R7
    doReset();
    for (int c = 0; c < 5; c++) begin
      step();
      for (int i = 0; i < NIN; i++) setPkt(i, 0, 0, 0, 0, 0);
      #1; expNone(); addG(0, c % NIN, 0); check("R7 round robin at output 0");
    end
  endtask

  task automatic tLrsHold();  // R9
    doReset();
    step(); setPkt(0,0,0,0,0,0); setPkt(1,0,0,0,0,0);
    #1; expNone(); addG(0,0,0); check("R9 first grant");
    step(); setPkt(0,0,0,0,0,0); setPkt(3,0,0,0,0,0);
    #1; expNone(); addG(0,3,0); check("R9 second grant");
    for (int c = 0; c < 2; c++) begin
      step(); outBusy[0] = 1'b1;
      for (int i = 0; i < NIN; i++) setPkt(i,0,0,0,0,0);
      #1; expNone(); check("R9 blocked cycle");
    end
    step(); setPkt(1,0,0,0,0,0); setPkt(2,0,0,0,0,0);
    #1; expNone(); addG(0,1,0); check("R9 order kept across blocked cycles");
    step(); setPkt(0,0,0,0,0,0); setPkt(3,0,0,0,0,0);
    #1; expNone(); addG(0,0,0); check("R9 order after further grant");
  endtask

  task automatic tClass();  // R4
    doReset();
    step();
    setPkt(0,0,2,0,1,7); setPkt(3,0,2,1,0,0);
    setPkt(1,0,1,0,1,7); setPkt(1,1,3,1,0,0);
    #1; expNone(); addG(2,3,0); addG(3,1,1); check("R4 response over request both levels");
  endtask

  task automatic tRotary();  // R5
    doReset();
    step();
    setPkt(0,0,1,0,0,7); setPkt(2,0,1,0,1,0);
    setPkt(3,0,0,0,0,5); setPkt(3,1,2,0,1,0);
    #1; expNone(); addG(1,2,0); addG(2,3,1); check("R5 through-traffic over local");
  endtask

  task automatic tAge();  // R6
    doReset();
    step();
    setPkt(0,0,3,0,1,2); setPkt(1,0,3,0,1,6);
    setPkt(2,0,0,0,0,1); setPkt(2,1,1,0,0,4);
    #1; expNone(); addG(3,1,0); addG(1,2,1); check("R6 older wins");
  endtask

  task automatic tLrsLocal();  // R8
    doReset();
    for (int c = 0; c < 3; c++) begin
      step(); setPkt(1,0,0,0,0,0); setPkt(1,1,1,0,0,0);
      #1; expNone(); addG(c % 2, 1, c % 2); check("R8 slot alternation");
    end
  endtask

  task automatic tBusy();  // R1
    doReset();
    step(); outBusy = 4'b0001;
    setPkt(0,0,0,1,1,7); setPkt(0,1,1,0,0,0);
    setPkt(1,0,2,1,1,7); pktValid[1][0] = 1'b0;
    #1; expNone(); addG(1,0,1); check("R1 busy and invalid ignored");
    step();
    setPkt(0,0,0,1,1,7); setPkt(0,1,1,0,0,0);
    setPkt(1,0,2,1,1,7); pktValid[1][0] = 1'b0;
    #1; expNone(); addG(0,0,0); check("R1 renominated once output frees");
  endtask

  task automatic tOneNom();  // R10
    doReset();
    step();
    setPkt(0,0,0,1,0,1); setPkt(0,1,1,0,0,0); setPkt(1,0,0,1,1,0);
    #1; expNone(); addG(0,1,0); check("R10 losing input gets no second chance");
  endtask

  task automatic tLoad();  // R2, R3
    doReset();
    for (int cyc = 0; cyc < 6; cyc++) begin
      step();
      for (int i = 0; i < NIN; i++)
        for (int s = 0; s < NSLOT; s++)
          setPkt(i, s, (i + s + cyc) % NOUT, 1'((i ^ cyc) & 1), 1'(s), (i*3 + cyc) % 8);
      if (cyc == 3) outBusy = 4'b0101;
      #1;
      begin
        int total = 0;
        bit r2ok = 1'b1;
        for (int o = 0; o < NOUT; o++) begin
          if ($countones(grantOut[o]) > 1) r2ok = 1'b0;
          total += $countones(grantOut[o]);
        end
        for (int i = 0; i < NIN; i++) begin
          int n = 0;
          for (int o = 0; o < NOUT; o++) n += int'(grantOut[o][i]);
          if (n > 1 || $countones(grantSlot[i]) != n) r2ok = 1'b0;
          for (int s = 0; s < NSLOT; s++)
            if (grantSlot[i][s] && !grantOut[pktDest[i][s]][i]) r2ok = 1'b0;
        end
        checkBit("R2 single grant per output and input", r2ok, int'(r2ok), 1);
        checkBit("R3 some grant issued", total > 0, total, 1);
      end
    end
  endtask

  initial begin
    clearIn();
    expNone();
    repeat (3) @(posedge clk);
    tReset();
    tLrsGlobal();
    tLrsHold();
    tClass();
    tRotary();
    tAge();
    tLrsLocal();
    tBusy();
    tOneNom();
    tLoad();
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule